// File: doc/BRIEF.md
# Microcontroller Power Mode and Reset Controller

This block decides, cycle by cycle, which clocks of a small 8-bit microcontroller may run and when the core's registers are put back to their initial values. Software picks a low-power state by writing one of two control bits. The idle state halts only the instruction engine. Timers, serial logic, the interrupt logic and on-chip RAM keep running. The power-down state stops the oscillator and, with it, every other block.

An external reset pin is qualified before it takes effect. It must stay high while the machine-cycle tick keeps arriving for more than two machine cycles, and only then is the internal reset raised. That qualified reset is the only way out of power-down. It reinitialises the registers and leaves RAM untouched, because this block never resets memory. A pending enabled interrupt ends idle, and the core then resumes with interrupt service followed by the instruction after the one that entered idle.

Top module: `pwr_rst_ctrl`

## Requirements
- R1: After the power-on reset (`rst_n` low), the mode is run: `cpu_clk_en`, `per_clk_en` and `osc_en` are 1, and `core_rst`, `idle_flag` and `pd_flag` are 0.
- R2: `core_rst` rises only after `rst_pin` has been high on three consecutive counted machine-cycle ticks (more than QUAL_CYCLES = 2). It stays 0 after only two such ticks.
- R3: Whenever `rst_pin` is low at a clock edge, the qualification count returns to zero. A low pin between ticks restarts the count, and `core_rst` falls at the first clock edge that sees the pin low.
- R4: A control write in run mode with `pcon_idle` = 1 and `pcon_pd` = 0 enters idle at that edge. In idle, `cpu_clk_en` = 0, `per_clk_en` = 1, `osc_en` = 1 and `idle_flag` = 1.
- R5: In idle, `irq_pend` = 1 at a clock edge returns the block to run at that edge. `cpu_clk_en` becomes 1 and `idle_flag` clears by itself.
- R6: A control write in run mode with `pcon_pd` = 1 enters power-down at that edge. While `rst_pin` is low, `cpu_clk_en`, `per_clk_en` and `osc_en` are all 0 and `pd_flag` = 1.
- R7: A write with both `pcon_idle` and `pcon_pd` set enters power-down, not idle.
- R8: In power-down, `irq_pend` has no effect. A high `rst_pin` sets `osc_en` to 1 at once. Once `core_rst` is qualified, the next edge returns to run and `pd_flag` clears by itself.
- R9: Control writes are ignored in idle, in power-down and while `core_rst` is 1. `irq_pend` has no effect in run mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| rst_pin | input | 1 | External reset pin, active high, synchronous to clk |
| mc_tick | input | 1 | One-cycle pulse per machine cycle, present only while the oscillator runs |
| pcon_wr | input | 1 | Write strobe for the power control bits |
| pcon_idle | input | 1 | Idle request bit written with the strobe |
| pcon_pd | input | 1 | Power-down request bit written with the strobe |
| irq_pend | input | 1 | An enabled interrupt is pending |
| cpu_clk_en | output | 1 | Clock enable for the instruction engine |
| per_clk_en | output | 1 | Clock enable for timers, serial port, interrupt logic and RAM |
| osc_en | output | 1 | Oscillator enable |
| core_rst | output | 1 | Qualified internal reset for core registers |
| idle_flag | output | 1 | Idle control bit as read back |
| pd_flag | output | 1 | Power-down control bit as read back |

## Verification
Every mode change happens at the clock edge that samples the write or the interrupt, so the enables and flags are due one edge after the stimulus. The bench drives on the falling edge and reads on the following falling edge. `core_rst` rises at the edge that counts the third tick with the pin high and falls at the first edge that sees the pin low. The return to run follows one edge later. `osc_en` follows the pin combinationally, so it is read shortly after the pin changes, with no edge in between. Each scenario task counts the edges itself and checks just before and just after the due edge. This catches results that arrive one cycle early or one cycle late.

// File: rtl/pmrc_pkg.sv
package pmrc_pkg;

    typedef enum logic [1:0] {
        MODE_RUN   = 2'd0,
        MODE_IDLE  = 2'd1,
        MODE_PDOWN = 2'd2
    } pm_mode_e;

    typedef struct packed {
        pm_mode_e mode;
    } fsm_state_t;

endpackage

// File: rtl/pmrc_rst_qual.sv
module pmrc_rst_qual #(
    parameter int QUAL_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rst_pin,
    input  logic mc_tick,
    output logic qual_rst
);
    localparam int LIMIT = QUAL_CYCLES + 1;
    localparam int CW    = $clog2(LIMIT + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } qual_state_t;

    qual_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!rst_pin) begin
            st_d.cnt = '0;
        end else if (mc_tick && (st_q.cnt != CW'(LIMIT))) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign qual_rst = (st_q.cnt == CW'(LIMIT));

    // R3: a low pin always empties the count
    p_cnt_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_pin |=> (st_q.cnt == '0));

    // R2: reset only rises after a tick seen with the pin high
    p_rise_needs_pin_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(qual_rst) |-> ($past(rst_pin) && $past(mc_tick)));

    // R2: counter saturates at its limit
    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(LIMIT));
endmodule

// File: rtl/pmrc_mode_fsm.sv
module pmrc_mode_fsm
    import pmrc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     qual_rst,
    input  logic     pcon_wr,
    input  logic     pcon_idle,
    input  logic     pcon_pd,
    input  logic     irq_pend,
    output pm_mode_e mode
);
    fsm_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (qual_rst) begin
            st_d.mode = MODE_RUN;
        end else begin
            unique case (st_q.mode)
                MODE_RUN: begin
                    if (pcon_wr && pcon_pd)        st_d.mode = MODE_PDOWN;
                    else if (pcon_wr && pcon_idle) st_d.mode = MODE_IDLE;
                end
                MODE_IDLE: begin
                    if (irq_pend) st_d.mode = MODE_RUN;
                end
                MODE_PDOWN: begin
                    st_d.mode = MODE_PDOWN;
                end
                default: st_d.mode = MODE_RUN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{mode: MODE_RUN};
        else        st_q <= st_d;
    end

    assign mode = st_q.mode;

    // R7: power-down wins over idle on a joint write
    p_pd_priority_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_RUN && pcon_wr && pcon_pd && !qual_rst)
        |=> (st_q.mode == MODE_PDOWN));

    // R5: a pending interrupt leaves idle
    p_idle_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_IDLE && irq_pend && !qual_rst) |=> (st_q.mode == MODE_RUN));

    // R8: only the qualified reset leaves power-down
    p_pd_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_PDOWN && !qual_rst) |=> (st_q.mode == MODE_PDOWN));

    // R9: writes ignored outside run
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_IDLE && !irq_pend && !qual_rst) |=> (st_q.mode == MODE_IDLE));
endmodule

// File: rtl/pmrc_clk_ctl.sv
module pmrc_clk_ctl
    import pmrc_pkg::*;
(
    input  pm_mode_e mode,
    input  logic     rst_pin,
    output logic     cpu_clk_en,
    output logic     per_clk_en,
    output logic     osc_en,
    output logic     idle_flag,
    output logic     pd_flag
);
    always_comb begin
        idle_flag  = (mode == MODE_IDLE);
        pd_flag    = (mode == MODE_PDOWN);
        cpu_clk_en = (mode == MODE_RUN);
        per_clk_en = !pd_flag;
        osc_en     = !pd_flag || rst_pin;
    end
endmodule

// File: rtl/pwr_rst_ctrl.sv
module pwr_rst_ctrl #(
    parameter int QUAL_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rst_pin,
    input  logic mc_tick,
    input  logic pcon_wr,
    input  logic pcon_idle,
    input  logic pcon_pd,
    input  logic irq_pend,
    output logic cpu_clk_en,
    output logic per_clk_en,
    output logic osc_en,
    output logic core_rst,
    output logic idle_flag,
    output logic pd_flag
);
    import pmrc_pkg::*;

    pm_mode_e mode;
    logic     qual_rst;

    pmrc_rst_qual #(.QUAL_CYCLES(QUAL_CYCLES)) u_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .rst_pin  (rst_pin),
        .mc_tick  (mc_tick),
        .qual_rst (qual_rst)
    );

    pmrc_mode_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .qual_rst  (qual_rst),
        .pcon_wr   (pcon_wr),
        .pcon_idle (pcon_idle),
        .pcon_pd   (pcon_pd),
        .irq_pend  (irq_pend),
        .mode      (mode)
    );

    pmrc_clk_ctl u_ctl (
        .mode       (mode),
        .rst_pin    (rst_pin),
        .cpu_clk_en (cpu_clk_en),
        .per_clk_en (per_clk_en),
        .osc_en     (osc_en),
        .idle_flag  (idle_flag),
        .pd_flag    (pd_flag)
    );

    assign core_rst = qual_rst;

    // R8: a high pin in power-down restarts the oscillator
    p_osc_on_pin_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_flag && rst_pin) |-> osc_en);

    // R6: power-down with the pin low stops every clock
    p_pd_all_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_flag && !rst_pin) |-> (!osc_en && !cpu_clk_en && !per_clk_en));

    // R4: idle keeps peripherals clocked
    p_idle_periph_r4: assert property (@(posedge clk) disable iff (!rst_n)
        idle_flag |-> (per_clk_en && osc_en && !cpu_clk_en));
endmodule

// File: tb/pwr_rst_ctrl_test.sv
module pwr_rst_ctrl_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rst_pin = 1'b0, tick_req = 1'b0;
    logic pcon_wr = 1'b0, pcon_idle = 1'b0, pcon_pd = 1'b0, irq_pend = 1'b0;
    logic mc_tick;
    logic cpu_clk_en, per_clk_en, osc_en, core_rst, idle_flag, pd_flag;
    int   n_chk = 0, n_err = 0;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;

    // the tick exists only while the oscillator runs
    assign mc_tick = tick_req && osc_en;

    pwr_rst_ctrl uut (
        .clk(clk), .rst_n(rst_n), .rst_pin(rst_pin), .mc_tick(mc_tick),
        .pcon_wr(pcon_wr), .pcon_idle(pcon_idle), .pcon_pd(pcon_pd),
        .irq_pend(irq_pend), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
        .osc_en(osc_en), .core_rst(core_rst), .idle_flag(idle_flag), .pd_flag(pd_flag)
    );

    task automatic check(string req, string what, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic check_outs(string req, logic c, logic p, logic o, logic r, logic i, logic d);
        check(req, "cpu_clk_en", cpu_clk_en, c);
        check(req, "per_clk_en", per_clk_en, p);
        check(req, "osc_en",     osc_en,     o);
        check(req, "core_rst",   core_rst,   r);
        check(req, "idle_flag",  idle_flag,  i);
        check(req, "pd_flag",    pd_flag,    d);
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic write_pcon(logic idle_b, logic pd_b);
        pcon_wr = 1'b1; pcon_idle = idle_b; pcon_pd = pd_b;
        step();
        pcon_wr = 1'b0; pcon_idle = 1'b0; pcon_pd = 1'b0;
    endtask

    // pin high with a tick each cycle: core_rst due after third edge
    task automatic qualify_reset(string req);
        rst_pin = 1'b1; tick_req = 1'b1;
        step(); step();
        check(req, "core_rst after two ticks", core_rst, 1'b0);
        step();
        check(req, "core_rst after three ticks", core_rst, 1'b1);
    endtask

    task automatic release_reset(string req);
        rst_pin = 1'b0; tick_req = 1'b0;
        step();
        check(req, "core_rst after pin low", core_rst, 1'b0);
    endtask

    task automatic t_reset_state();
        check_outs("R1", 1, 1, 1, 0, 0, 0);
    endtask

    task automatic t_qualify();
        qualify_reset("R2");
        step();
        check_outs("R2", 1, 1, 1, 1, 0, 0);
        release_reset("R3");
    endtask

    task automatic t_restart();
        rst_pin = 1'b1; tick_req = 1'b1;
        step(); step();
        rst_pin = 1'b0;
        step();
        rst_pin = 1'b1;
        step(); step();
        check("R3", "core_rst after restart two ticks", core_rst, 1'b0);
        step();
        check("R3", "core_rst after restart third tick", core_rst, 1'b1);
        release_reset("R3");
    endtask

    task automatic t_idle();
        irq_pend = 1'b1;
        step();
        check_outs("R9", 1, 1, 1, 0, 0, 0);  // irq in run: no effect
        irq_pend = 1'b0;
        write_pcon(1'b1, 1'b0);
        check_outs("R4", 0, 1, 1, 0, 1, 0);
        write_pcon(1'b0, 1'b1);               // ignored in idle
        check_outs("R9", 0, 1, 1, 0, 1, 0);
        step();
        check_outs("R9", 0, 1, 1, 0, 1, 0);
        irq_pend = 1'b1;
        step();
        irq_pend = 1'b0;
        check_outs("R5", 1, 1, 1, 0, 0, 0);
    endtask

    task automatic t_pdown(logic both, string req);
        write_pcon(both, 1'b1);
        check_outs(req, 0, 0, 0, 0, 0, 1);
        irq_pend = 1'b1;
        step();
        irq_pend = 1'b0;
        check_outs("R8", 0, 0, 0, 0, 0, 1);
        tick_req = 1'b1;                       // no oscillator, no ticks
        step(); step(); step();
        check("R8", "core_rst without pin", core_rst, 1'b0);
        rst_pin = 1'b1;
        #1;
        check("R8", "osc_en on pin high", osc_en, 1'b1);
        step(); step();
        check("R8", "pd_flag before qualify", pd_flag, 1'b1);
        step();
        check("R8", "core_rst qualified", core_rst, 1'b1);
        check("R8", "pd_flag same edge", pd_flag, 1'b1);
        write_pcon(1'b1, 1'b0);               // exits pd; write ignored under reset
        check_outs("R8", 1, 1, 1, 1, 0, 0);
        check("R9", "idle_flag write under reset", idle_flag, 1'b0);
        release_reset("R8");
        check_outs("R8", 1, 1, 1, 0, 0, 0);
    endtask

    task automatic t_rst_from_idle();
        write_pcon(1'b1, 1'b0);
        check("R4", "idle_flag", idle_flag, 1'b1);
        qualify_reset("R2");
        step();
        check("R2", "idle_flag cleared by reset", idle_flag, 1'b0);
        release_reset("R3");
    endtask

    initial begin
        #1;
        check_outs("R1", 1, 1, 1, 0, 0, 0);
        step();
        rst_n = 1'b1;
        step();
        t_reset_state();
        t_qualify();
        t_restart();
        t_idle();
        t_pdown(1'b0, "R6");
        t_pdown(1'b1, "R7");
        t_rst_from_idle();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_err++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule